// File: doc/BRIEF.md
# Null-Terminated Serial Block Transfer Engine

This block moves a zero-terminated message between memory and a byte-wide serial port in both directions, so the host does no work per byte. On the transmit side it fetches multi-byte words from a source memory, starting at a programmable word address. It hands their bytes to the serial transmitter, most significant byte first. It stops once it has handed over a byte equal to zero. On the receive side it stores every byte the receiver delivers into a buffer at a rising address, and it stops when a zero byte arrives.

The host starts each direction with a one-cycle start pulse and a base address, then watches the done flags. The two directions share no state, so a message can be looped from the transmitter back into the receiver while both are running. The receive direction also takes an upper address limit. If the buffer fills to that limit before a terminator arrives, reception stops and an overflow flag is raised. The terminator byte is itself transmitted, and on receive it is stored.

Top module: `nt_xfer_engine`

## Requirements
- R1: One cycle after `tx_start` is sampled, `mem_rd_en` is high and `mem_rd_addr` equals the `tx_base` that was sampled with the start.
- R2: Each source word is read once and its bytes are sent from the most significant byte (bits 15:8 with the default two-byte word) down to the least significant byte. The word address then rises by one for the next read.
- R3: The first byte after a start is loaded (`ser_tx_load` high) three cycles after `tx_start` is sampled, whatever the level of `ser_tx_empty`. Every later byte is loaded only in a cycle where `ser_tx_empty` is high.
- R4: A byte equal to zero is itself loaded. `tx_done` rises in the following cycle, and after that there is no memory read and no byte load until the next `tx_start`.
- R5: `rx_start` sets the write pointer to `rx_base`. A byte presented with `ser_rx_valid` is written one cycle later, with `buf_wr_en` high, `buf_wr_addr` equal to the pointer and `buf_wr_data` equal to the byte.
- R6: The write pointer rises by one after each non-zero byte is stored, so consecutive non-zero bytes land at consecutive addresses.
- R7: A zero byte is stored at the current pointer and `rx_done` is high in the same cycle as that write. Bytes that arrive later produce no write until the next `rx_start`.
- R8: When a non-zero byte is stored at address `rx_limit`, `rx_overflow` rises in the same cycle as that write, `rx_done` stays low and later bytes produce no write. A zero byte stored at `rx_limit` ends the message normally, without overflow.
- R9: Transmit and receive run at the same time without affecting each other, so a message looped from the transmit byte output into the receive input is stored intact.
- R10: After reset, `mem_rd_en`, `ser_tx_load`, `tx_done`, `buf_wr_en`, `rx_done` and `rx_overflow` are all low.
- R11: A start pulse clears that direction's done flag, and on receive also the overflow flag, by the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | Start pulse for the transmit direction |
| tx_base | input | WADDR_W | First source word address |
| mem_rd_en | output | 1 | Source memory read strobe |
| mem_rd_addr | output | WADDR_W | Source word address |
| mem_rd_data | input | BYTE_W*WORD_BYTES | Source word, valid the cycle after the strobe |
| ser_tx_empty | input | 1 | Transmitter can accept a byte; must fall by the cycle after a load |
| ser_tx_load | output | 1 | Load strobe for the transmitter |
| ser_tx_byte | output | BYTE_W | Byte handed to the transmitter |
| tx_done | output | 1 | Terminator has been handed to the transmitter |
| rx_start | input | 1 | Start pulse for the receive direction |
| rx_base | input | BADDR_W | First buffer address |
| rx_limit | input | BADDR_W | Last usable buffer address |
| ser_rx_valid | input | 1 | Receiver holds a new byte this cycle |
| ser_rx_byte | input | BYTE_W | Received byte |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_addr | output | BADDR_W | Buffer write address |
| buf_wr_data | output | BYTE_W | Buffer write data |
| rx_done | output | 1 | Terminator has been stored |
| rx_overflow | output | 1 | Buffer limit reached without a terminator |

## Verification
On transmit, the read strobe is due one cycle after the start is sampled and the first byte load three cycles after. After the low byte of a word, the next read comes one cycle later, and `tx_done` follows the terminator load by exactly one cycle. On receive, the buffer write is due one cycle after the byte is presented, and `rx_done` or `rx_overflow` shows in that same cycle. The bench logs strobes one nanosecond after each rising edge together with a cycle counter, and it compares logged cycle numbers against these offsets from the recorded start cycle rather than waiting loosely. Checks that something is ignored look at the write and load strobes in the cycles where a response would have been due.

// File: rtl/nt_xfer_pkg.sv
package nt_xfer_pkg;

   // Transmit sequencer states
   typedef enum logic [1:0] {
      TXS_IDLE = 2'd0,  // stopped, waiting for a start pulse
      TXS_READ = 2'd1,  // read strobe to source memory
      TXS_CAPT = 2'd2,  // memory data is valid, latch the word
      TXS_WAIT = 2'd3   // offer the selected byte to the transmitter
   } txs_e;

endpackage

// File: rtl/nt_tx_path.sv
module nt_tx_path
   import nt_xfer_pkg::*;
#(
   parameter int WADDR_W    = 8,
   parameter int BYTE_W     = 8,
   parameter int WORD_BYTES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           start,
   input  logic [WADDR_W-1:0]             base,
   output logic                           rd_en,
   output logic [WADDR_W-1:0]             rd_addr,
   input  logic [BYTE_W*WORD_BYTES-1:0]   rd_data,
   input  logic                           tx_empty,
   output logic                           tx_load,
   output logic [BYTE_W-1:0]              tx_byte,
   output logic                           done
);

   localparam int WORD_W = BYTE_W * WORD_BYTES;
   localparam int IDX_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WORD_BYTES - 1);

   txs_e                state_q;
   logic [WADDR_W-1:0]  addr_q;
   logic [WORD_W-1:0]   word_q;
   logic [IDX_W-1:0]    bidx_q;
   logic                first_q;   // first byte after start skips the empty wait
   logic                done_q;
   logic [BYTE_W-1:0]   cur_byte;

   // Byte lane selection: a single-byte word needs no multiplexer
   generate
      if (WORD_BYTES == 1) begin : g_one_lane
         assign cur_byte = word_q;
      end else begin : g_lanes
         logic [BYTE_W-1:0] lane [WORD_BYTES];
         for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
            assign lane[g] = word_q[g*BYTE_W +: BYTE_W];
         end
         assign cur_byte = lane[bidx_q];
      end
   endgenerate

   assign rd_en   = (state_q == TXS_READ);
   assign rd_addr = addr_q;
   assign tx_load = (state_q == TXS_WAIT) && (tx_empty || first_q);
   assign tx_byte = cur_byte;
   assign done    = done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= TXS_IDLE;
         addr_q  <= '0;
         word_q  <= '0;
         bidx_q  <= '0;
         first_q <= 1'b0;
         done_q  <= 1'b0;
      end else if (start) begin
         state_q <= TXS_READ;
         addr_q  <= base;
         bidx_q  <= TOP_IDX;
         first_q <= 1'b1;
         done_q  <= 1'b0;
      end else begin
         unique case (state_q)
            TXS_READ: state_q <= TXS_CAPT;
            TXS_CAPT: begin
               word_q  <= rd_data;
               state_q <= TXS_WAIT;
            end
            TXS_WAIT: begin
               if (tx_load) begin
                  first_q <= 1'b0;
                  if (cur_byte == '0) begin
                     done_q  <= 1'b1;
                     state_q <= TXS_IDLE;
                  end else if (bidx_q == '0) begin
                     addr_q  <= addr_q + WADDR_W'(1);
                     bidx_q  <= TOP_IDX;
                     state_q <= TXS_READ;
                  end else begin
                     bidx_q  <= bidx_q - IDX_W'(1);
                  end
               end
            end
            default: state_q <= TXS_IDLE;
         endcase
      end
   end

   // R1: a start produces a read of the base address next cycle
   assert_start_reads_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (rd_en && rd_addr == $past(base)));

   // R2: each word is fetched with a single-cycle strobe
   assert_single_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en);

   // R3: a read and a byte load never share a cycle
   assert_no_load_in_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !tx_load);

   // R4: once finished, the path stays quiet until restarted
   assert_quiet_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !start) |=> (!tx_load && !rd_en));

   // R4: a zero byte load is followed by the done flag
   assert_zero_sets_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && tx_byte == '0 && !start) |=> done_q);

endmodule

// File: rtl/nt_rx_path.sv
module nt_rx_path #(
   parameter int BADDR_W = 8,
   parameter int BYTE_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [BADDR_W-1:0] base,
   input  logic [BADDR_W-1:0] limit,
   input  logic               rx_valid,
   input  logic [BYTE_W-1:0]  rx_byte,
   output logic               wr_en,
   output logic [BADDR_W-1:0] wr_addr,
   output logic [BYTE_W-1:0]  wr_data,
   output logic               done,
   output logic               overflow
);

   logic               active_q;
   logic [BADDR_W-1:0] ptr_q;
   logic [BADDR_W-1:0] lim_q;
   logic               wr_en_q;
   logic [BADDR_W-1:0] wr_addr_q;
   logic [BYTE_W-1:0]  wr_data_q;
   logic               done_q;
   logic               ovf_q;
   logic               take;

   assign take     = active_q && rx_valid;
   assign wr_en    = wr_en_q;
   assign wr_addr  = wr_addr_q;
   assign wr_data  = wr_data_q;
   assign done     = done_q;
   assign overflow = ovf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q  <= 1'b0;
         ptr_q     <= '0;
         lim_q     <= '0;
         wr_en_q   <= 1'b0;
         wr_addr_q <= '0;
         wr_data_q <= '0;
         done_q    <= 1'b0;
         ovf_q     <= 1'b0;
      end else begin
         wr_en_q <= 1'b0;
         if (start) begin
            active_q <= 1'b1;
            ptr_q    <= base;
            lim_q    <= limit;
            done_q   <= 1'b0;
            ovf_q    <= 1'b0;
         end else if (take) begin
            wr_en_q   <= 1'b1;
            wr_addr_q <= ptr_q;
            wr_data_q <= rx_byte;
            if (rx_byte == '0) begin
               done_q   <= 1'b1;
               active_q <= 1'b0;
            end else if (ptr_q == lim_q) begin
               ovf_q    <= 1'b1;
               active_q <= 1'b0;
            end else begin
               ptr_q <= ptr_q + BADDR_W'(1);
            end
         end
      end
   end

   // R5: start loads the pointer from the base input
   assert_start_loads_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (ptr_q == $past(base)));

   // R6: a stored non-zero byte below the limit moves the pointer by one
   assert_ptr_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !start && rx_byte != '0 && ptr_q != lim_q) |=> (ptr_q == $past(ptr_q) + BADDR_W'(1)));

   // R7: a zero byte is written and finishes reception in the same cycle
   assert_zero_finishes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !start && rx_byte == '0) |=> (wr_en && wr_data == '0 && done_q));

   // R7, R8: after finishing either way, no further writes until restart
   assert_no_write_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((done_q || ovf_q) && !start) |=> !wr_en);

   // R8: normal end and overflow are never flagged together
   assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_q && ovf_q));

endmodule

// File: rtl/nt_xfer_engine.sv
module nt_xfer_engine #(
   parameter int WADDR_W    = 8,
   parameter int BADDR_W    = 8,
   parameter int BYTE_W     = 8,
   parameter int WORD_BYTES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          tx_start,
   input  logic [WADDR_W-1:0]            tx_base,
   output logic                          mem_rd_en,
   output logic [WADDR_W-1:0]            mem_rd_addr,
   input  logic [BYTE_W*WORD_BYTES-1:0]  mem_rd_data,
   input  logic                          ser_tx_empty,
   output logic                          ser_tx_load,
   output logic [BYTE_W-1:0]             ser_tx_byte,
   output logic                          tx_done,
   input  logic                          rx_start,
   input  logic [BADDR_W-1:0]            rx_base,
   input  logic [BADDR_W-1:0]            rx_limit,
   input  logic                          ser_rx_valid,
   input  logic [BYTE_W-1:0]             ser_rx_byte,
   output logic                          buf_wr_en,
   output logic [BADDR_W-1:0]            buf_wr_addr,
   output logic [BYTE_W-1:0]             buf_wr_data,
   output logic                          rx_done,
   output logic                          rx_overflow
);

   // Elaboration-time parameter checks
   generate
      if (WADDR_W < 1 || BADDR_W < 1) begin : g_bad_addr
         $error("nt_xfer_engine: address widths must be at least 1");
      end
      if (BYTE_W < 1) begin : g_bad_byte
         $error("nt_xfer_engine: BYTE_W must be at least 1");
      end
      if (WORD_BYTES < 1 || WORD_BYTES > 16) begin : g_bad_word
         $error("nt_xfer_engine: WORD_BYTES must lie in 1..16");
      end
   endgenerate

   nt_tx_path #(
      .WADDR_W    (WADDR_W),
      .BYTE_W     (BYTE_W),
      .WORD_BYTES (WORD_BYTES)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (tx_start),
      .base     (tx_base),
      .rd_en    (mem_rd_en),
      .rd_addr  (mem_rd_addr),
      .rd_data  (mem_rd_data),
      .tx_empty (ser_tx_empty),
      .tx_load  (ser_tx_load),
      .tx_byte  (ser_tx_byte),
      .done     (tx_done)
   );

   nt_rx_path #(
      .BADDR_W (BADDR_W),
      .BYTE_W  (BYTE_W)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (rx_start),
      .base     (rx_base),
      .limit    (rx_limit),
      .rx_valid (ser_rx_valid),
      .rx_byte  (ser_rx_byte),
      .wr_en    (buf_wr_en),
      .wr_addr  (buf_wr_addr),
      .wr_data  (buf_wr_data),
      .done     (rx_done),
      .overflow (rx_overflow)
   );

   // R10: nothing is strobed or flagged in the cycle right after reset
   assert_reset_quiet_R10: assert property (@(posedge clk)
      $rose(rst_n) |-> (!mem_rd_en && !ser_tx_load && !tx_done && !buf_wr_en && !rx_done && !rx_overflow));

   // R11: a start clears the flags of its own direction
   assert_tx_start_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_start |=> !tx_done);
   assert_rx_start_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_start |=> (!rx_done && !rx_overflow));

endmodule

// File: tb/nt_xfer_engine_tb.sv
`timescale 1ns/1ps
module nt_xfer_engine_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_start = 1'b0;
   logic [7:0]  tx_base = '0;
   logic        mem_rd_en;
   logic [7:0]  mem_rd_addr;
   logic [15:0] mem_rd_data;
   logic        ser_tx_empty;
   logic        ser_tx_load;
   logic [7:0]  ser_tx_byte;
   logic        tx_done;
   logic        rx_start = 1'b0;
   logic [7:0]  rx_base = '0;
   logic [7:0]  rx_limit = '0;
   logic        ser_rx_valid = 1'b0;
   logic [7:0]  ser_rx_byte = '0;
   logic        buf_wr_en;
   logic [7:0]  buf_wr_addr;
   logic [7:0]  buf_wr_data;
   logic        rx_done;
   logic        rx_overflow;

   always #2.5 clk = ~clk;

   nt_xfer_engine u_dut (
      .clk(clk), .rst_n(rst_n),
      .tx_start(tx_start), .tx_base(tx_base),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .ser_tx_empty(ser_tx_empty), .ser_tx_load(ser_tx_load), .ser_tx_byte(ser_tx_byte),
      .tx_done(tx_done),
      .rx_start(rx_start), .rx_base(rx_base), .rx_limit(rx_limit),
      .ser_rx_valid(ser_rx_valid), .ser_rx_byte(ser_rx_byte),
      .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_data(buf_wr_data),
      .rx_done(rx_done), .rx_overflow(rx_overflow)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // Source memory model: registered read
   logic [15:0] mem [256];
   logic [15:0] mem_q = '0;
   assign mem_rd_data = mem_q;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mem_rd_en) mem_q <= mem[mem_rd_addr];
   end

   // Transmitter model: empty drops on load, returns after tx_lat cycles unless held
   logic tx_hold = 1'b0;
   int   tx_lat  = 2;
   int   bcnt    = 0;
   always @(posedge clk) begin
      if (!rst_n) begin
         ser_tx_empty <= 1'b1;
         bcnt <= 0;
      end else if (ser_tx_load) begin
         ser_tx_empty <= 1'b0;
         bcnt <= tx_lat;
      end else if (bcnt != 0) begin
         bcnt <= bcnt - 1;
      end else begin
         ser_tx_empty <= !tx_hold;
      end
   end

   // Logs, sampled 1 ns after each rising edge
   logic [7:0] tx_log [64];
   int         tx_cyc [64];
   int         tx_n = 0;
   logic [7:0] rd_log [64];
   int         rd_n = 0;
   logic [7:0] buf_mem [256];
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         if (ser_tx_load) begin
            if (tx_n < 64) begin
               tx_log[tx_n] = ser_tx_byte;
               tx_cyc[tx_n] = cyc;
            end
            tx_n++;
         end
         if (mem_rd_en) begin
            if (rd_n < 64) rd_log[rd_n] = mem_rd_addr;
            rd_n++;
         end
         if (buf_wr_en) buf_mem[buf_wr_addr] = buf_wr_data;
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_logs();
      tx_n = 0;
      rd_n = 0;
   endtask

   task automatic t_reset();
      chk("R10 mem_rd_en", mem_rd_en, 0);
      chk("R10 ser_tx_load", ser_tx_load, 0);
      chk("R10 tx_done", tx_done, 0);
      chk("R10 buf_wr_en", buf_wr_en, 0);
      chk("R10 rx_done", rx_done, 0);
      chk("R10 rx_overflow", rx_overflow, 0);
   endtask

   // Multi-word message, first byte sent while transmitter reports busy
   task automatic t_tx_message();
      int c0;
      mem[8'h10] = 16'h4142; mem[8'h11] = 16'h4344;
      mem[8'h12] = 16'h0045; mem[8'h13] = 16'h4647;
      tx_hold = 1'b1; tx_lat = 2;
      repeat (4) tick();
      chk("R3 empty held low", ser_tx_empty, 0);
      clear_logs();
      c0 = cyc;
      tx_base = 8'h10; tx_start = 1'b1;
      tick();
      tx_start = 1'b0;
      chk("R1 read strobe", mem_rd_en, 1);
      chk("R1 read addr", mem_rd_addr, 8'h10);
      repeat (6) tick();
      chk("R3 one load while busy", tx_n, 1);
      chk("R3 first load cycle", tx_cyc[0], c0 + 3);
      chk("R2 first byte high", tx_log[0], 8'h41);
      tx_hold = 1'b0;
      for (int i = 0; i < 80 && !tx_done; i++) tick();
      chk("R4 tx_done", tx_done, 1);
      chk("R4 byte count", tx_n, 5);
      chk("R2 byte1", tx_log[1], 8'h42);
      chk("R2 byte2", tx_log[2], 8'h43);
      chk("R2 byte3", tx_log[3], 8'h44);
      chk("R4 terminator sent", tx_log[4], 8'h00);
      chk("R2 read count", rd_n, 3);
      chk("R2 read order", {rd_log[0], rd_log[1], rd_log[2]}, 24'h101112);
      chk("R4 done one cycle after terminator", cyc, tx_cyc[4] + 1);
      repeat (30) tick();
      chk("R4 no loads after done", tx_n, 5);
      chk("R4 no reads after done", rd_n, 3);
   endtask

   // Terminator as the very first byte, then restart behaviour
   task automatic t_tx_zero_first();
      int c0;
      mem[8'h30] = 16'h0099;
      clear_logs();
      c0 = cyc;
      tx_base = 8'h30; tx_start = 1'b1;
      tick();
      tx_start = 1'b0;
      chk("R11 tx_done cleared", tx_done, 0);
      tick(); tick();
      chk("R4 no done before load", tx_done, 0);
      chk("R3 first load at start+3", ser_tx_load, 1);
      chk("R3 load cycle", cyc, c0 + 3);
      tick();
      chk("R4 done after zero-first", tx_done, 1);
      repeat (10) tick();
      chk("R4 zero-first single byte", tx_n, 1);
      chk("R4 zero-first byte", tx_log[0], 0);
      chk("R4 zero-first single read", rd_n, 1);
   endtask

   // Terminator in the low byte
   task automatic t_tx_low_zero();
      mem[8'h40] = 16'h5A00; mem[8'h41] = 16'h7777;
      clear_logs();
      tx_base = 8'h40; tx_start = 1'b1;
      tick();
      tx_start = 1'b0;
      for (int i = 0; i < 40 && !tx_done; i++) tick();
      repeat (10) tick();
      chk("R4 low-zero count", tx_n, 2);
      chk("R2 low-zero high", tx_log[0], 8'h5A);
      chk("R4 low-zero term", tx_log[1], 8'h00);
      chk("R2 low-zero reads", rd_n, 1);
   endtask

   task automatic rx_send(input logic [7:0] b, input int exp_en, input logic [7:0] exp_addr,
                          input string tag);
      ser_rx_valid = 1'b1; ser_rx_byte = b;
      tick();
      ser_rx_valid = 1'b0;
      chk({tag, " write strobe"}, buf_wr_en, exp_en);
      if (exp_en != 0) begin
         chk({tag, " write addr"}, buf_wr_addr, exp_addr);
         chk({tag, " write data"}, buf_wr_data, b);
      end
      tick();
   endtask

   task automatic t_rx_message();
      rx_base = 8'h20; rx_limit = 8'h2F; rx_start = 1'b1;
      tick();
      rx_start = 1'b0;
      rx_send(8'h48, 1, 8'h20, "R5 first byte");
      rx_send(8'h69, 1, 8'h21, "R6 second byte");
      ser_rx_valid = 1'b1; ser_rx_byte = 8'h00;
      tick();
      ser_rx_valid = 1'b0;
      chk("R7 zero stored", buf_wr_en, 1);
      chk("R7 zero addr", buf_wr_addr, 8'h22);
      chk("R7 done with write", rx_done, 1);
      chk("R7 no overflow", rx_overflow, 0);
      tick();
      rx_send(8'h55, 0, 8'h00, "R7 ignored after done");
      chk("R7 done kept", rx_done, 1);
   endtask

   task automatic t_rx_overflow();
      rx_base = 8'h40; rx_limit = 8'h42; rx_start = 1'b1;
      tick();
      rx_start = 1'b0;
      chk("R11 rx_done cleared", rx_done, 0);
      rx_send(8'h01, 1, 8'h40, "R8 fill 0");
      rx_send(8'h02, 1, 8'h41, "R8 fill 1");
      ser_rx_valid = 1'b1; ser_rx_byte = 8'h03;
      tick();
      ser_rx_valid = 1'b0;
      chk("R8 write at limit", buf_wr_addr, 8'h42);
      chk("R8 overflow with write", rx_overflow, 1);
      chk("R8 done stays low", rx_done, 0);
      tick();
      rx_send(8'h04, 0, 8'h00, "R8 ignored after overflow");
      // zero byte exactly at the limit ends normally
      rx_base = 8'h50; rx_limit = 8'h50; rx_start = 1'b1;
      tick();
      rx_start = 1'b0;
      chk("R11 overflow cleared", rx_overflow, 0);
      ser_rx_valid = 1'b1; ser_rx_byte = 8'h00;
      tick();
      ser_rx_valid = 1'b0;
      chk("R8 zero at limit addr", buf_wr_addr, 8'h50);
      chk("R8 zero at limit done", rx_done, 1);
      chk("R8 zero at limit no overflow", rx_overflow, 0);
      tick();
   endtask

   // Loopback: transmit bytes fed straight back into the receive side
   task automatic t_concurrent();
      mem[8'h60] = 16'h4F4B; mem[8'h61] = 16'h2100; mem[8'h62] = 16'h3333;
      for (int a = 8'h80; a < 8'h88; a++) buf_mem[a] = 8'hEE;
      tx_lat = 3;
      tx_base = 8'h60; rx_base = 8'h80; rx_limit = 8'hFF;
      tx_start = 1'b1; rx_start = 1'b1;
      tick();
      tx_start = 1'b0; rx_start = 1'b0;
      for (int i = 0; i < 200 && !(tx_done && rx_done); i++) begin
         ser_rx_valid = ser_tx_load;
         ser_rx_byte  = ser_tx_byte;
         tick();
      end
      ser_rx_valid = 1'b0;
      repeat (3) tick();
      chk("R9 tx_done", tx_done, 1);
      chk("R9 rx_done", rx_done, 1);
      chk("R9 buf0", buf_mem[8'h80], 8'h4F);
      chk("R9 buf1", buf_mem[8'h81], 8'h4B);
      chk("R9 buf2", buf_mem[8'h82], 8'h21);
      chk("R9 buf3", buf_mem[8'h83], 8'h00);
      chk("R9 buf4 untouched", buf_mem[8'h84], 8'hEE);
      chk("R9 no overflow", rx_overflow, 0);
   endtask

   bit finished = 1'b0;

   initial begin
      for (int a = 0; a < 256; a++) begin
         mem[a] = 16'h0000;
         buf_mem[a] = 8'h00;
      end
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_tx_message();
      t_tx_zero_first();
      t_tx_low_zero();
      t_rx_message();
      t_rx_overflow();
      t_concurrent();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog act=running exp=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule